// File: doc/BRIEF.md
# Serial Port Frame-Sync and Transmit Clock Generator

This block sits beside the sample-rate divider of a synchronous serial port. It makes the frame-sync pulse and picks the transmit bit clock. Everything runs on the fast system clock. The divided bit clock reaches the block in two forms: a one-cycle enable `gen_tick`, which marks each divided-clock period, and the level of that divided clock, `gen_clk_lvl`.

Two conditions must hold before the frame-sync output starts: the generator must be out of reset, and internal frame sync must be selected. Once running, two countdown counters reload together at each frame start. A width counter sets how long the pulse stays high. A period counter sets how long each frame lasts. Both values are sampled at the start of each frame.

A clock-source bit picks the internal transmit clock. It is either the external clock pin or the divided clock. The same bit sets the pin direction. A polarity bit inverts the clock on the pin side.

Top module: `fsync_clkgen_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `fs_out`, `tx_clk_int`, `tx_pin_out` and `tx_pin_oe` are all 0.
- R2: `fs_out` stays low until a `gen_tick` arrives with both `gen_run` and `fs_internal` at 1. One clock edge after that tick, `fs_out` is 1 and a frame begins.
- R3: If either `gen_run` or `fs_internal` is 0 at a clock edge, `fs_out` is 0 after that edge. Whatever the tick, the next run starts a fresh frame.
- R4: Within a frame, `fs_out` stays high for exactly `fs_width`+1 ticks, then goes low.
- R5: A frame lasts `fs_period`+1 ticks, and the next frame starts on the following tick. Width and period are sampled only at frame start, so a change takes effect from the next frame.
- R6: When `fs_width` >= `fs_period`, `fs_out` stays high for the whole frame and across frame boundaries.
- R7: With `clk_src_gen`=0, the pin is an input. `tx_pin_oe`=0, `tx_pin_out`=0, and `tx_clk_int` equals `ext_clk_pin` XOR `clk_pol`, one clock edge later.
- R8: With `clk_src_gen`=1, the pin is an output. `tx_pin_oe`=1, `tx_pin_out` equals `gen_clk_lvl` XOR `clk_pol`, and `tx_clk_int` equals `gen_clk_lvl`, all one clock edge later.
- R9: While running, the counters and `fs_out` change only on clock edges where `gen_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_tick | input | 1 | One-cycle enable per divided-clock period |
| gen_clk_lvl | input | 1 | Level of the divided bit clock |
| gen_run | input | 1 | Generator released from reset |
| fs_internal | input | 1 | Selects internally generated frame sync |
| fs_width | input | 8 | Pulse width minus one, in ticks |
| fs_period | input | 12 | Frame period minus one, in ticks |
| clk_src_gen | input | 1 | 1: transmit clock from divided clock; 0: from pin |
| clk_pol | input | 1 | Inverts the pin-side clock |
| ext_clk_pin | input | 1 | Clock level arriving on the transmit-clock pin |
| fs_out | output | 1 | Frame-sync output |
| tx_clk_int | output | 1 | Internal transmit clock |
| tx_pin_out | output | 1 | Value driven onto the transmit-clock pin |
| tx_pin_oe | output | 1 | Pin output enable |

## Verification
All four outputs are registered. Each one is due at the first rising clock edge after the stimulus that causes it. For the frame-sync output, that stimulus is the tick. For the clock outputs, it is the level present before the edge.

The bench's reference model advances at every rising edge, using the inputs held stable since the previous falling edge. It compares every output 2 ns after that edge, so each result is checked in the exact cycle it is due. Tick spacing is varied, including one tick every cycle, so the tick-to-edge relation is exercised at several rates.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  // Source of the internal transmit clock
  typedef enum logic {
    CLK_FROM_PIN = 1'b0,
    CLK_FROM_GEN = 1'b1
  } clk_src_e;
endpackage

// File: rtl/fsc_period_ctr.sv
module fsc_period_ctr #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             frame_start
);
  logic             started;
  logic [PER_W-1:0] pcnt;

  // A new frame begins on the first tick of a run or once the period is used up
  assign frame_start = run & tick & (~started | (pcnt == '0));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      started <= 1'b0;
      pcnt    <= '0;
    end else if (tick) begin
      started <= 1'b1;
      // loading period counts the start tick itself, i.e. period+1 ticks per frame
      if (frame_start) pcnt <= period;
      else             pcnt <= pcnt - 1'b1;
    end
  end

  AST_PCNT_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(pcnt)); // R9
endmodule

// File: rtl/fsc_width_ctr.sv
module fsc_width_ctr #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             frame_start,
  input  logic [WID_W-1:0] width,
  output logic             hold_high
);
  logic [WID_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      wcnt <= '0;
    end else if (tick) begin
      if (frame_start)      wcnt <= width;
      else if (wcnt != '0)  wcnt <= wcnt - 1'b1;
    end
  end

  assign hold_high = (wcnt != '0);

  AST_WCNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !frame_start && wcnt == '0) |=> (wcnt == '0)); // R4
endmodule

// File: rtl/fsc_clk_mux.sv
module fsc_clk_mux
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src_gen,
  input  logic pol,
  input  logic gen_lvl,
  input  logic pin_in,
  output logic clk_int,
  output logic pin_out,
  output logic pin_oe
);
  clk_src_e src;
  assign src = clk_src_e'(src_gen);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_int <= 1'b0;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else if (src == CLK_FROM_GEN) begin
      clk_int <= gen_lvl;
      pin_out <= gen_lvl ^ pol;
      pin_oe  <= 1'b1;
    end else begin
      clk_int <= pin_in ^ pol;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end
  end

  AST_PIN_QUIET_AS_INPUT: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out); // R7
  AST_OE_TRACKS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    src_gen |=> pin_oe); // R8
endmodule

// File: rtl/fsync_clkgen_top.sv
module fsync_clkgen_top #(
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_tick,
  input  logic             gen_clk_lvl,
  input  logic             gen_run,
  input  logic             fs_internal,
  input  logic [WID_W-1:0] fs_width,
  input  logic [PER_W-1:0] fs_period,
  input  logic             clk_src_gen,
  input  logic             clk_pol,
  input  logic             ext_clk_pin,
  output logic             fs_out,
  output logic             tx_clk_int,
  output logic             tx_pin_out,
  output logic             tx_pin_oe
);
  logic run;
  logic frame_start;
  logic hold_high;

  assign run = gen_run & fs_internal;

  fsc_period_ctr #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst(rst), .run(run), .tick(gen_tick),
    .period(fs_period), .frame_start(frame_start)
  );

  fsc_width_ctr #(.WID_W(WID_W)) u_width (
    .clk(clk), .rst(rst), .run(run), .tick(gen_tick),
    .frame_start(frame_start), .width(fs_width), .hold_high(hold_high)
  );

  fsc_clk_mux u_clk (
    .clk(clk), .rst(rst), .src_gen(clk_src_gen), .pol(clk_pol),
    .gen_lvl(gen_clk_lvl), .pin_in(ext_clk_pin),
    .clk_int(tx_clk_int), .pin_out(tx_pin_out), .pin_oe(tx_pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst || !run)      fs_out <= 1'b0;
    else if (gen_tick) begin
      if (frame_start)    fs_out <= 1'b1;
      else if (!hold_high) fs_out <= 1'b0;
    end
  end

  AST_FS_LOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> !fs_out); // R3
  AST_FS_HIGH_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> fs_out); // R2
  AST_FS_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !gen_tick) |=> $stable(fs_out)); // R9
endmodule

// File: tb/fsync_clkgen_top_test.sv
module fsync_clkgen_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_tick = 1'b0;
  logic        gen_clk_lvl = 1'b0;
  logic        gen_run = 1'b0;
  logic        fs_internal = 1'b0;
  logic [7:0]  fs_width = '0;
  logic [11:0] fs_period = '0;
  logic        clk_src_gen = 1'b0;
  logic        clk_pol = 1'b0;
  logic        ext_clk_pin = 1'b0;
  logic        fs_out, tx_clk_int, tx_pin_out, tx_pin_oe;

  always #5 clk = ~clk;

  fsync_clkgen_top uut (
    .clk(clk), .rst(rst), .gen_tick(gen_tick), .gen_clk_lvl(gen_clk_lvl),
    .gen_run(gen_run), .fs_internal(fs_internal), .fs_width(fs_width),
    .fs_period(fs_period), .clk_src_gen(clk_src_gen), .clk_pol(clk_pol),
    .ext_clk_pin(ext_clk_pin), .fs_out(fs_out), .tx_clk_int(tx_clk_int),
    .tx_pin_out(tx_pin_out), .tx_pin_oe(tx_pin_oe)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string req_tag = "R1";
  int    div = 3;
  int    dcnt = 0;
  logic [7:0] lfsr = 8'h5a;
  bit    done = 1'b0;

  // divided-clock stimulus: tick every div cycles, level toggles per tick
  always @(negedge clk) begin
    if (dcnt >= div - 1) begin
      dcnt = 0;
      gen_tick <= 1'b1;
      gen_clk_lvl <= ~gen_clk_lvl;
    end else begin
      dcnt++;
      gen_tick <= 1'b0;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ext_clk_pin <= lfsr[0];
  end

  // reference model: frame position counter
  bit m_act = 0;
  int m_pos = 0, m_lw = 0, m_lp = 0;
  bit e_fs = 0, e_int = 0, e_pin = 0, e_oe = 0;

  task automatic check(input logic act, input bit exp, input string what, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; e_fs = 0; e_int = 0; e_pin = 0; e_oe = 0;
    end else begin
      if (!(gen_run && fs_internal)) begin
        m_act = 0; e_fs = 0;
      end else if (gen_tick) begin
        if (!m_act || m_pos == m_lp) begin
          m_act = 1; m_pos = 0; m_lw = int'(fs_width); m_lp = int'(fs_period);
        end else begin
          m_pos++;
        end
        e_fs = (m_pos <= m_lw);
      end
      if (clk_src_gen) begin
        e_int = gen_clk_lvl; e_pin = gen_clk_lvl ^ clk_pol; e_oe = 1;
      end else begin
        e_int = ext_clk_pin ^ clk_pol; e_pin = 0; e_oe = 0;
      end
    end
    #2;
    if (!done) begin
      check(fs_out, e_fs, "fs_out", req_tag);
      check(tx_clk_int, e_int, "tx_clk_int", rst ? "R1" : (e_oe ? "R8" : "R7"));
      check(tx_pin_out, e_pin, "tx_pin_out", rst ? "R1" : (e_oe ? "R8" : "R7"));
      check(tx_pin_oe, e_oe, "tx_pin_oe", rst ? "R1" : (e_oe ? "R8" : "R7"));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_run();
    gen_run = 0; fs_internal = 0;
    wait_cyc(3);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    req_tag = "R1";
    wait_cyc(5);
    rst = 0;
    wait_cyc(2);
    // R2: released but internal sync not selected -> low
    req_tag = "R2";
    fs_width = 8'd2; fs_period = 12'd7;
    gen_run = 1; wait_cyc(20);
    fs_internal = 1; wait_cyc(10);
    req_tag = "R4"; wait_cyc(60);
    req_tag = "R5"; wait_cyc(60);
    // R5: new fields take effect at the next frame start
    fs_width = 8'd1; fs_period = 12'd3; wait_cyc(80);
    // R3: drop mode select mid-frame, then generator release
    req_tag = "R3";
    fs_internal = 0; wait_cyc(10);
    fs_internal = 1; wait_cyc(17);
    gen_run = 0; wait_cyc(8);
    gen_run = 1; wait_cyc(30);
    stop_run();
    // R6: width equal to and above period
    req_tag = "R6";
    fs_width = 8'd5; fs_period = 12'd5;
    gen_run = 1; fs_internal = 1; wait_cyc(80);
    stop_run();
    fs_width = 8'd9; fs_period = 12'd4;
    gen_run = 1; fs_internal = 1; wait_cyc(80);
    stop_run();
    // R9: tick every cycle, then sparse ticks
    req_tag = "R9";
    div = 1;
    fs_width = 8'd0; fs_period = 12'd2;
    gen_run = 1; fs_internal = 1; wait_cyc(40);
    stop_run();
    div = 4;
    fs_width = 8'd3; fs_period = 12'd6;
    gen_run = 1; fs_internal = 1; wait_cyc(100);
    // R8 / R7: clock source and polarity
    req_tag = "R4";
    clk_src_gen = 1; clk_pol = 0; wait_cyc(60);
    clk_pol = 1; wait_cyc(60);
    clk_src_gen = 0; clk_pol = 1; wait_cyc(60);
    clk_pol = 0; wait_cyc(30);
    // R1: reset mid-run
    req_tag = "R1";
    rst = 1; wait_cyc(4);
    rst = 0; stop_run();
    wait_cyc(2);
    finish_up();
  end

  initial begin
    #2000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule